// File: doc/BRIEF.md
# Two-Loop Digital Gain Controller

This block steers one gain index shared by both antennas of a two-antenna complex receive path. It works during the short training part of a packet. Each pass starts with a measurement window. Over a fixed number of samples, the window adds up the magnitude sum |I|+|Q| separately for each antenna. The larger of the two totals is taken and turned into a coarse logarithmic code, in which one step equals 3 dB.

The converter saturation flag may rise while the window is open. In that case the window is abandoned at once and the gain index drops by a programmable coarse amount. Otherwise a fine correction moves the index toward a programmable target code. A signal that is above the target is cut by a further programmable margin. After each update, the controller waits for a programmable settling time. It then measures again, until a pass finds the level at or below the target. That last update is followed by a final wait, a one-cycle completion pulse and a hold of the gain index. The hold lasts until the enable input is cycled.

The amplifier that applies the index, and the detector that raises the saturation flag, are separate blocks. The index counts 3 dB steps from 0 up to `GAIN_MAX`.

Top module: `agc_twoloop`

## Requirements
- R1: While reset is held, `gain_idx` is 0 and `done` is 0. Once reset is released with `enable` low, `gain_idx` follows `cfg_ginit`.
- R2: A measurement window lasts `MEAS_LEN` (32) consecutive samples. For each antenna it sums |I|+|Q|, where a sample is a two's-complement value and -2048 has magnitude 2048. The larger antenna total is the one used.
- R3: The level code is 2·p + b. Here p is the bit position of the leading one of the selected total and b is the bit just below it; a total of zero gives code 0. For example, a total of 96 gives code 13, 64 gives 12 and 256 gives 16.
- R4: If the code is below `cfg_vref`, the index rises by `cfg_vref` minus the code. The final wait follows.
- R5: If the code is above `cfg_vref`, the index falls by the code minus `cfg_vref`, plus `cfg_cut_extra`. The controller then waits and measures again.
- R6: If the code equals `cfg_vref`, the index is unchanged. The final wait follows.
- R7: If `sat_flag` is high on any sample of an open window, the window ends on that sample. The next cycle lowers the index by `cfg_cut_big`, and the controller then waits and measures again.
- R8: `sat_flag` has no effect outside a measurement window.
- R9: Every update saturates the index to the range 0..`GAIN_MAX` (32).
- R10: Each wait lasts `cfg_delay` cycles; a value of 0 acts as 1. When the final wait ends, `done` is high for exactly one cycle.
- R11: After `done`, the controller stays idle and holds `gain_idx`, whatever the input samples do, until `enable` goes low.
- R12: `enable` low forces the idle state from any state on the next edge. It also loads `gain_idx` from `cfg_ginit` and keeps `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low returns the controller to idle |
| ant0_i | input | SMP_W | Antenna 0 in-phase sample, signed |
| ant0_q | input | SMP_W | Antenna 0 quadrature sample, signed |
| ant1_i | input | SMP_W | Antenna 1 in-phase sample, signed |
| ant1_q | input | SMP_W | Antenna 1 quadrature sample, signed |
| sat_flag | input | 1 | Converter saturation indication, aligned with the samples |
| cfg_ginit | input | GAIN_W | Starting gain index |
| cfg_vref | input | LOG_W | Target level code |
| cfg_cut_big | input | GAIN_W | Coarse cut applied on saturation |
| cfg_cut_extra | input | GAIN_W | Extra cut added when above target |
| cfg_delay | input | DLY_W | Settling wait in cycles |
| gain_idx | output | GAIN_W | Gain index in 3 dB steps |
| done | output | 1 | One-cycle pulse when the final wait ends |

## Verification
The bound checker watches four things on every cycle:
- the index stays inside its range;
- `done` never lasts two cycles;
- disabling reloads the start index and suppresses `done`;
- the index stays frozen after completion while enable remains high.

The arithmetic of the level code, the choice of the larger antenna, the sign of each correction, the coarse cut on saturation, the indifference to saturation during waits and the exact length of the waits can only be seen through the bench's scenarios. Those scenarios drive constant sample patterns through whole passes and compare the index after each update with values worked out from the rules.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MEAS,
    ST_CUT_BIG,
    ST_TRIM,
    ST_WAIT_MORE,
    ST_WAIT_FINAL
  } agc_state_e;
endpackage

// File: rtl/agc_level_meter.sv
// Per-antenna |I|+|Q| accumulators and selection of the larger total (R2).
module agc_level_meter #(
  parameter int SMP_W = 12,
  parameter int N_ANT = 2,
  parameter int ACC_W = 18
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       en,
  input  logic [2*N_ANT*SMP_W-1:0]   smp_flat,
  output logic [ACC_W-1:0]           level_max
);
  localparam int MAG_W = SMP_W + 1;

  function automatic logic [MAG_W-1:0] mag_of(input logic [SMP_W-1:0] v);
    logic [MAG_W-1:0] e;
    e = {v[SMP_W-1], v};
    return v[SMP_W-1] ? (~e + 1'b1) : e;
  endfunction

  logic [N_ANT*ACC_W-1:0] acc_all;

  for (genvar a = 0; a < N_ANT; a++) begin : g_ant
    logic [SMP_W-1:0] s_i, s_q;
    logic [MAG_W:0]   mag_sum;
    logic [ACC_W-1:0] acc_q;

    assign s_i     = smp_flat[(2*a)*SMP_W +: SMP_W];
    assign s_q     = smp_flat[(2*a+1)*SMP_W +: SMP_W];
    assign mag_sum = {1'b0, mag_of(s_i)} + {1'b0, mag_of(s_q)};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q <= '0;
      end else if (clr) begin
        acc_q <= '0;
      end else if (en) begin
        acc_q <= acc_q + ACC_W'(mag_sum);
      end
    end

    assign acc_all[a*ACC_W +: ACC_W] = acc_q;
  end

  always_comb begin
    level_max = '0;
    for (int a = 0; a < N_ANT; a++) begin
      if (acc_all[a*ACC_W +: ACC_W] > level_max) level_max = acc_all[a*ACC_W +: ACC_W];
    end
  end
endmodule

// File: rtl/agc_log_conv.sv
// Leading-one position doubled plus the next bit down: 3 dB per code step (R3).
module agc_log_conv #(
  parameter int IN_W  = 18,
  localparam int POS_W = $clog2(IN_W),
  localparam int OUT_W = POS_W + 1
) (
  input  logic [IN_W-1:0]  level,
  output logic [OUT_W-1:0] code
);
  logic [POS_W-1:0] pos;
  logic             below;

  always_comb begin
    pos = '0;
    for (int k = 0; k < IN_W; k++) begin
      if (level[k]) pos = POS_W'(k);
    end
    below = (pos != '0) ? level[pos - 1'b1] : 1'b0;
    code  = {pos, below};
  end
endmodule

// File: rtl/agc_gain_step.sv
// Computes the next gain index for a coarse or fine update, saturated to range.
module agc_gain_step #(
  parameter int GAIN_W   = 6,
  parameter int GAIN_MAX = 32,
  parameter int LOG_W    = 6
) (
  input  logic [GAIN_W-1:0] gain_cur,
  input  logic [LOG_W-1:0]  level_code,
  input  logic [LOG_W-1:0]  target,
  input  logic [GAIN_W-1:0] cut_big,
  input  logic [GAIN_W-1:0] cut_extra,
  input  logic              coarse,
  output logic [GAIN_W-1:0] gain_new,
  output logic              final_pass
);
  localparam int CW = ((GAIN_W > LOG_W) ? GAIN_W : LOG_W) + 3;

  logic signed [CW-1:0] cur, err, delta, sum;

  always_comb begin
    cur = $signed(CW'(gain_cur));
    err = $signed(CW'(target)) - $signed(CW'(level_code));
    if (coarse) begin
      delta = -$signed(CW'(cut_big));
    end else if (err >= 0) begin
      delta = err;
    end else begin
      delta = err - $signed(CW'(cut_extra));
    end
    sum = cur + delta;
    if (sum < 0) begin
      gain_new = '0;
    end else if (sum > $signed(CW'(GAIN_MAX))) begin
      gain_new = GAIN_W'(GAIN_MAX);
    end else begin
      gain_new = sum[GAIN_W-1:0];
    end
    final_pass = !coarse && (err >= 0);
  end
endmodule

// File: rtl/agc_twoloop.sv
module agc_twoloop #(
  parameter int SMP_W    = 12,
  parameter int MEAS_LEN = 32,
  parameter int GAIN_MAX = 32,
  parameter int DLY_W    = 8,
  localparam int GAIN_W  = $clog2(GAIN_MAX + 1),
  localparam int ACC_W   = SMP_W + 1 + $clog2(MEAS_LEN),
  localparam int LOG_W   = $clog2(ACC_W) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic signed [SMP_W-1:0]  ant0_i,
  input  logic signed [SMP_W-1:0]  ant0_q,
  input  logic signed [SMP_W-1:0]  ant1_i,
  input  logic signed [SMP_W-1:0]  ant1_q,
  input  logic                     sat_flag,
  input  logic [GAIN_W-1:0]        cfg_ginit,
  input  logic [LOG_W-1:0]         cfg_vref,
  input  logic [GAIN_W-1:0]        cfg_cut_big,
  input  logic [GAIN_W-1:0]        cfg_cut_extra,
  input  logic [DLY_W-1:0]         cfg_delay,
  output logic [GAIN_W-1:0]        gain_idx,
  output logic                     done
);
  import agc_pkg::*;

  localparam int MEAS_W = $clog2(MEAS_LEN);
  localparam int CNT_W  = (MEAS_W > DLY_W) ? MEAS_W : DLY_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  agc_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [GAIN_W-1:0] gain_q, gain_d;
  logic              fin_q, fin_d;
  logic              done_q, done_d;

  logic [ACC_W-1:0]  level;
  logic [LOG_W-1:0]  level_code;
  logic [GAIN_W-1:0] step_gain;
  logic              step_final;
  logic [GAIN_W-1:0] ginit_sat;
  logic              meas_last, wait_over;

  agc_level_meter #(.SMP_W(SMP_W), .N_ANT(2), .ACC_W(ACC_W)) u_meter (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .clr       (state_q != ST_MEAS),
    .en        (state_q == ST_MEAS),
    .smp_flat  ({ant1_q, ant1_i, ant0_q, ant0_i}),
    .level_max (level)
  );

  agc_log_conv #(.IN_W(ACC_W)) u_log (
    .level (level),
    .code  (level_code)
  );

  agc_gain_step #(.GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX), .LOG_W(LOG_W)) u_step (
    .gain_cur   (gain_q),
    .level_code (level_code),
    .target     (cfg_vref),
    .cut_big    (cfg_cut_big),
    .cut_extra  (cfg_cut_extra),
    .coarse     (state_q == ST_CUT_BIG),
    .gain_new   (step_gain),
    .final_pass (step_final)
  );

  assign ginit_sat = (cfg_ginit > GAIN_W'(GAIN_MAX)) ? GAIN_W'(GAIN_MAX) : cfg_ginit;
  assign meas_last = (cnt_q == CNT_W'(MEAS_LEN - 1));
  assign wait_over = ((CNT_W+1)'(cnt_q) + 1'b1) >= (CNT_W+1)'(cfg_delay);

  always_comb begin
    state_d = state_q;
    gain_d  = gain_q;
    fin_d   = fin_q;
    done_d  = 1'b0;
    if (!enable) begin
      state_d = ST_IDLE;
      gain_d  = ginit_sat;
      fin_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (!fin_q) begin
            gain_d  = ginit_sat;
            state_d = ST_MEAS;
          end
        end
        ST_MEAS: begin
          if (sat_flag)       state_d = ST_CUT_BIG;
          else if (meas_last) state_d = ST_TRIM;
        end
        ST_CUT_BIG: begin
          gain_d  = step_gain;
          state_d = ST_WAIT_MORE;
        end
        ST_TRIM: begin
          gain_d  = step_gain;
          state_d = step_final ? ST_WAIT_FINAL : ST_WAIT_MORE;
        end
        ST_WAIT_MORE: begin
          if (wait_over) state_d = ST_MEAS;
        end
        ST_WAIT_FINAL: begin
          if (wait_over) begin
            state_d = ST_IDLE;
            fin_d   = 1'b1;
            done_d  = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
    cnt_d = (state_d != state_q) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      gain_q  <= '0;
      fin_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (gain_d != gain_q) gain_q <= gain_d;
      fin_q   <= fin_d;
      done_q  <= done_d;
    end
  end

  assign gain_idx = gain_q;
  assign done     = done_q;
endmodule

// File: rtl/agc_twoloop_chk.sv
module agc_twoloop_chk #(
  parameter int GAIN_W   = 6,
  parameter int GAIN_MAX = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [GAIN_W-1:0] cfg_ginit,
  input logic [GAIN_W-1:0] gain_idx,
  input logic              done
);
  logic fin_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fin_seen <= 1'b0;
    else if (!enable) fin_seen <= 1'b0;
    else if (done)    fin_seen <= 1'b1;
  end

  p_gain_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gain_idx <= GAIN_W'(GAIN_MAX));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_disable_reload_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && cfg_ginit <= GAIN_W'(GAIN_MAX)) |=> gain_idx == $past(cfg_ginit));

  p_disable_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !done);

  p_hold_after_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_seen && enable) |=> $stable(gain_idx));
endmodule

bind agc_twoloop agc_twoloop_chk #(.GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .enable    (enable),
  .cfg_ginit (cfg_ginit),
  .gain_idx  (gain_idx),
  .done      (done)
);

// File: tb/agc_twoloop_test.sv
`timescale 1ns/1ps
module agc_twoloop_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n, enable, sat_flag;
  logic signed [11:0] a0i, a0q, a1i, a1q;
  logic [5:0]        cfg_ginit, cfg_vref, cfg_cut_big, cfg_cut_extra;
  logic [7:0]        cfg_delay;
  logic [5:0]        gain_idx;
  logic              done;

  agc_twoloop uut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .ant0_i(a0i), .ant0_q(a0q), .ant1_i(a1i), .ant1_q(a1q),
    .sat_flag(sat_flag), .cfg_ginit(cfg_ginit), .cfg_vref(cfg_vref),
    .cfg_cut_big(cfg_cut_big), .cfg_cut_extra(cfg_cut_extra),
    .cfg_delay(cfg_delay), .gain_idx(gain_idx), .done(done)
  );

  int nchk = 0;
  int nbad = 0;
  bit over = 0;

  typedef struct packed {
    logic signed [11:0] i0, q0, i1, q1;
    logic [5:0] ginit, vref, gexp;
    logic       last;
  } vec_t;

  // codes: 2,2 -> 128 -> 14 ; 1,0 -> 32 -> 10 ; 1,1 -> 64 -> 12 ; 3 -> 96 -> 13
  localparam vec_t TBL [8] = '{
    '{12'sd2,    12'sd2,  12'sd2,  12'sd2, 6'd20, 6'd13, 6'd11, 1'b0},
    '{12'sd1,    12'sd0,  12'sd0,  12'sd0, 6'd20, 6'd13, 6'd23, 1'b1},
    '{12'sd1,    12'sd1,  12'sd1,  12'sd1, 6'd20, 6'd13, 6'd21, 1'b1},
    '{12'sd2,    12'sd1,  12'sd0,  12'sd0, 6'd20, 6'd13, 6'd20, 1'b1},
    '{12'sd1,    12'sd0,  -12'sd3, 12'sd0, 6'd20, 6'd13, 6'd20, 1'b1},
    '{12'sd2047, 12'h800, 12'sd0,  12'sd0, 6'd20, 6'd13, 6'd0,  1'b0},
    '{12'sd0,    12'sd0,  12'sd0,  12'sd0, 6'd20, 6'd13, 6'd32, 1'b1},
    '{12'sd4,    12'sd4,  12'sd0,  12'sd0, 6'd5,  6'd20, 6'd9,  1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_smp(input logic signed [11:0] i0, q0, i1, q1);
    a0i = i0; a0q = q0; a1i = i1; a1q = q1;
  endtask

  // leaves the bench at the negedge before the first window sample
  task automatic start_run();
    enable = 1'b0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic window(input logic signed [11:0] i0, q0, i1, q1,
                        input int gexp, input bit last, input string req);
    set_smp(i0, q0, i1, q1);
    repeat (33) @(negedge clk);
    check(gain_idx == gexp, req, gain_idx, gexp);
    repeat (int'(cfg_delay) - 1) @(negedge clk);
    check(done == 1'b0, "R10 no early done", done, 0);
    @(negedge clk);
    check(done == last, {req, " R10 done at wait end"}, done, last);
    if (last) begin
      @(negedge clk);
      check(done == 1'b0, "R10 done one cycle", done, 0);
    end
  endtask

  task automatic sat_window(input int j, input int gexp, input string req);
    sat_flag = 1'b0;
    repeat (j - 1) @(negedge clk);
    sat_flag = 1'b1;
    @(negedge clk);
    sat_flag = 1'b0;
    @(negedge clk);
    check(gain_idx == gexp, req, gain_idx, gexp);
    repeat (int'(cfg_delay)) @(negedge clk);
    check(done == 1'b0, "R7 continues after coarse cut", done, 0);
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b0; sat_flag = 1'b0;
    set_smp(12'sd0, 12'sd0, 12'sd0, 12'sd0);
    cfg_ginit = 6'd20; cfg_vref = 6'd13; cfg_cut_big = 6'd12;
    cfg_cut_extra = 6'd8; cfg_delay = 8'd32;
    repeat (3) @(negedge clk);
    check(gain_idx == 0, "R1 reset gain", gain_idx, 0);
    check(done == 0, "R1 reset done", done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(gain_idx == 20, "R1 follows start index", gain_idx, 20);

    // table: R2 R3 R4 R5 R6 R9
    for (int n = 0; n < 8; n++) begin
      cfg_ginit = TBL[n].ginit;
      cfg_vref  = TBL[n].vref;
      start_run();
      window(TBL[n].i0, TBL[n].q0, TBL[n].i1, TBL[n].q1,
             int'(TBL[n].gexp), TBL[n].last, $sformatf("R2 R3 R4 R5 R6 R9 entry %0d", n));
    end
    cfg_ginit = 6'd20; cfg_vref = 6'd13;

    // two passes, saturation pulsed during the wait (R5, R8)
    start_run();
    set_smp(12'sd2, 12'sd2, 12'sd2, 12'sd2);
    repeat (33) @(negedge clk);
    check(gain_idx == 11, "R5 above target cut", gain_idx, 11);
    repeat (10) @(negedge clk);
    sat_flag = 1'b1;
    repeat (3) @(negedge clk);
    sat_flag = 1'b0;
    repeat (32 - 13 - 1) @(negedge clk);
    check(gain_idx == 11, "R8 sat in wait no effect", gain_idx, 11);
    @(negedge clk);
    window(12'sd1, 12'sd1, 12'sd1, 12'sd1, 12, 1'b1, "R8 second pass fine update");

    // hold after done (R11)
    set_smp(12'sd2047, 12'sd2047, 12'sd2047, 12'sd2047);
    sat_flag = 1'b1;
    repeat (100) @(negedge clk);
    sat_flag = 1'b0;
    check(gain_idx == 12, "R11 hold after done", gain_idx, 12);
    check(done == 0, "R11 no second done", done, 0);
    start_run();
    check(gain_idx == 20, "R11 restart reloads", gain_idx, 20);
    window(12'sd1, 12'sd1, 12'sd1, 12'sd1, 21, 1'b1, "R11 restart runs");

    // coarse loop and lower clamp (R7, R9)
    start_run();
    sat_window(5, 8, "R7 coarse cut mid window");
    sat_window(1, 0, "R7 R9 coarse cut clamps at 0");
    window(12'sd1, 12'sd0, 12'sd0, 12'sd0, 3, 1'b1, "R7 fine pass after coarse");

    // enable drop (R12)
    start_run();
    set_smp(12'sd2, 12'sd2, 12'sd2, 12'sd2);
    repeat (33) @(negedge clk);
    check(gain_idx == 11, "R12 pre-drop update", gain_idx, 11);
    repeat (5) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(gain_idx == 20, "R12 drop in wait reloads", gain_idx, 20);
    enable = 1'b1;
    repeat (12) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(gain_idx == 20, "R12 drop in window", gain_idx, 20);
    check(done == 0, "R12 no done", done, 0);

    // short wait (R10)
    cfg_delay = 8'd5;
    start_run();
    window(12'sd2, 12'sd2, 12'sd2, 12'sd2, 11, 1'b0, "R10 short wait pass 1");
    window(12'sd1, 12'sd1, 12'sd1, 12'sd1, 12, 1'b1, "R10 short wait pass 2");

    over = 1'b1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!over) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule